// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Generator

This block produces the three interrupt sources of a PC-style real-time clock and merges them into one request line. The periodic source comes from a programmable power-of-two divider clocked by single-cycle ticks of a 32.768 kHz reference. The alarm and update sources arrive as single-cycle pulses from timekeeping and comparison logic that lies outside this block.

Each source sets a sticky flag in a status byte, whether or not its enable bit is set. A summary bit in the status byte and the request output are raised only while at least one flag is set together with its enable. Software reaches the block through a byte-wide read/write strobe port with five addresses:

| Address | Register | Access |
|---|---|---|
| 0 | rate | read/write |
| 1 | control | read/write |
| 2 | status | read only |
| 3 | enable-set mask | write only |
| 4 | enable-clear mask | write only |

A status read returns the flags and then clears them.

Top module: `rtc_irq_gen`

## Requirements
- R1: After reset the rate register reads 0x26: code 6 in bits 3:0 and base select 3'b010 (32 kHz) in bits 6:4. Control and status read 0x00 and `irq` is low. A read returns data on `reg_rdata` one clock after the strobe.
- R2: While the rate code is 0, no periodic flag is ever set, however many reference ticks arrive.
- R3: With rate code n from 1 to 15, the periodic flag sets once every 2^(n-1) reference ticks, which is 2^(16-n) Hz. Code 1 sets it on every tick and code 15 sets it once every 16384 ticks.
- R4: An alarm, update or periodic event sets its flag even when the matching enable bit is clear.
- R5: The status register has the following bit layout:
  - bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update flag;
  - bit 7 is the summary bit;
  - bits 3:0 always read 0;
  - the enables sit at the same positions (6, 5, 4) in the control register.
- R6: The summary bit and `irq` are 1 exactly when some flag and its enable are both 1. This holds when an enable is set after its flag has already latched.
- R7: A write to address 3 sets, and a write to address 4 clears, the enable bits (6:4) that are 1 in the written data. All other control bits keep their value. A write to address 1 replaces the whole control byte.
- R8: A status read returns the status as it stood before the read and clears all flags (and so the summary bit and `irq`). An event that arrives in the same cycle as the read is not lost: it is set afterwards.
- R9: Any write to the rate register restarts the periodic divider, so the first periodic flag after the write comes one full new period of ticks later.
- R10: Writes to the status address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| alarm_evt | input | 1 | One-cycle alarm match pulse |
| update_evt | input | 1 | One-cycle end-of-update pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address (0 rate, 1 control, 2 status, 3 enable set, 4 enable clear) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench steps through rate codes from the fastest to the slowest setting and counts the ticks exactly. A divider that is off by one, or that maps the code to the wrong exponent, sets the flag one tick early or late and is caught. It writes the rate register mid-period and expects the full new period to follow. A divider that keeps its old count would fire early. It fires an alarm in the same cycle as a clearing status read. A design that lets the clear win loses that event. Flags that arrive while disabled, enables raised after a flag has latched, and set/clear masks carrying extra bits are all checked. These catch flags gated by their enables, a request line that ignores late enables, and masks that corrupt the other control bits.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned EVT_N    = 3;   // update, alarm, periodic
  localparam int unsigned EVT_LSB  = 4;   // flags/enables occupy bits 6:4
  localparam int unsigned SUM_BIT  = 7;
  localparam int unsigned IDX_UPD  = 0;   // bit 4
  localparam int unsigned IDX_ALM  = 1;   // bit 5
  localparam int unsigned IDX_PER  = 2;   // bit 6

  typedef enum logic [2:0] {
    ADR_RATE   = 3'd0,
    ADR_CTRL   = 3'd1,
    ADR_STAT   = 3'd2,
    ADR_EN_SET = 3'd3,
    ADR_EN_CLR = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic [RATE_W-1:0] code,
  output logic              per_evt
);
  localparam int unsigned DIV_W = (1 << RATE_W) - 2;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] term;
  logic             run;

  assign run = (code != '0);

  // Period in ticks is 2^(code-1); terminal count is one less.
  always_comb begin
    span = {{DIV_W{1'b0}}, 1'b1} << (code - {{(RATE_W-1){1'b0}}, 1'b1});
    term = span[DIV_W-1:0] - {{(DIV_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q   <= '0;
      per_evt <= 1'b0;
    end else begin
      per_evt <= 1'b0;
      if (tick && run) begin
        if (cnt_q == term) begin
          cnt_q   <= '0;
          per_evt <= 1'b1;
        end else begin
          cnt_q <= cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned RATE_W     = 4,
  parameter int unsigned SEL_W      = 3,
  parameter logic [3:0]  RESET_CODE = 4'd6,
  parameter logic [2:0]  RESET_SEL  = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rate_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] ctrl_nxt,
  output logic              rate_wr
);
  localparam int unsigned   FIELD_W   = RATE_W + SEL_W;
  localparam logic [BYTE_W-1:0] RATE_MASK = BYTE_W'((1 << FIELD_W) - 1);
  localparam logic [BYTE_W-1:0] EN_MASK   = BYTE_W'(((1 << EVT_N) - 1) << EVT_LSB);
  localparam logic [BYTE_W-1:0] RATE_RST  =
    BYTE_W'({RESET_SEL[SEL_W-1:0], RESET_CODE[RATE_W-1:0]});

  assign rate_wr = wr && (addr == ADR_RATE);

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr) begin
      unique case (addr)
        ADR_CTRL:   ctrl_nxt = wdata;
        ADR_EN_SET: ctrl_nxt = ctrl_q | (wdata & EN_MASK);
        ADR_EN_CLR: ctrl_nxt = ctrl_q & ~(wdata & EN_MASK);
        default:    ctrl_nxt = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RATE_RST;
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      if (rate_wr) rate_q <= wdata & RATE_MASK;
    end
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_N-1:0] evt,
  input  logic             clr,
  input  logic [EVT_N-1:0] en_nxt,
  output logic [EVT_N-1:0] flg_q,
  output logic             irq_q
);
  logic [EVT_N-1:0] flg_nxt;

  for (genvar gi = 0; gi < EVT_N; gi++) begin : g_flag
    // A coinciding event survives the clearing read.
    assign flg_nxt[gi] = (flg_q[gi] & ~clr) | evt[gi];

    always_ff @(posedge clk) begin
      if (rst) flg_q[gi] <= 1'b0;
      else     flg_q[gi] <= flg_nxt[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flg_nxt & en_nxt);
  end
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
  import rtc_irq_pkg::*;
#(
  parameter int unsigned RATE_W     = 4,
  parameter int unsigned SEL_W      = 3,
  parameter logic [3:0]  RESET_CODE = 4'd6,
  parameter logic [2:0]  RESET_SEL  = 3'b010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [BYTE_W-1:0] rate_q, ctrl_q, ctrl_nxt, stat_byte;
  logic              rate_wr, per_evt, stat_rd, irq_q;
  logic [RATE_W-1:0] rate_code;
  logic [EVT_N-1:0]  flg, evt_vec;

  assign rate_code = rate_q[RATE_W-1:0];
  assign stat_rd   = reg_rd && (reg_addr == ADR_STAT);
  assign evt_vec   = {per_evt, alarm_evt, update_evt};
  assign stat_byte = {irq_q, flg, 4'b0000};
  assign irq       = irq_q;

  rtc_cfg_regs #(
    .RATE_W(RATE_W), .SEL_W(SEL_W),
    .RESET_CODE(RESET_CODE), .RESET_SEL(RESET_SEL)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rate_q(rate_q), .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt), .rate_wr(rate_wr)
  );

  rtc_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .restart(rate_wr), .tick(ref_tick),
    .code(rate_code), .per_evt(per_evt)
  );

  rtc_flag_unit u_flags (
    .clk(clk), .rst(rst), .evt(evt_vec), .clr(stat_rd),
    .en_nxt(ctrl_nxt[EVT_LSB +: EVT_N]), .flg_q(flg), .irq_q(irq_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        ADR_RATE: reg_rdata <= rate_q;
        ADR_CTRL: reg_rdata <= ctrl_q;
        ADR_STAT: reg_rdata <= stat_byte;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_irq_gen_chk.sv
module rtc_irq_gen_chk
  import rtc_irq_pkg::*;
#(
  parameter int unsigned RATE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [3:0]        rdata_low,
  input logic              alarm_evt,
  input logic              update_evt,
  input logic              per_evt,
  input logic [EVT_N-1:0]  flg,
  input logic [BYTE_W-1:0] ctrl_q,
  input logic [RATE_W-1:0] rate_code,
  input logic              irq
);
  p_alarm_latch_r4: assert property (@(posedge clk) disable iff (rst)
    alarm_evt |=> flg[IDX_ALM]);

  p_irq_match_r6: assert property (@(posedge clk) disable iff (rst)
    irq == |(flg & ctrl_q[EVT_LSB +: EVT_N]));

  p_code0_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |-> !per_evt);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADR_STAT && !alarm_evt && !update_evt && !per_evt)
      |=> (flg == '0));

  p_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADR_STAT) |=> (rdata_low == 4'b0000));

  p_set_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADR_EN_SET) |=>
      (ctrl_q[3:0] == $past(ctrl_q[3:0]) && ctrl_q[7] == $past(ctrl_q[7])));

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADR_RATE) |=> !per_evt);
endmodule

bind rtc_irq_gen rtc_irq_gen_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .rdata_low(reg_rdata[3:0]), .alarm_evt(alarm_evt), .update_evt(update_evt),
  .per_evt(per_evt), .flg(flg), .ctrl_q(ctrl_q), .rate_code(rate_code),
  .irq(irq)
);

// File: tb/sim_rtc_irq_gen.sv
`timescale 1ns/1ps
module sim_rtc_irq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0, alarm_evt = 1'b0, update_evt = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  localparam logic [2:0] A_RATE = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2,
                         A_SET = 3'd3, A_CLR = 3'd4;

  // {rate code, expected period in ticks}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 16'd1}, {4'd2, 16'd2}, {4'd3, 16'd4},
    {4'd6, 16'd32}, {4'd9, 16'd256}, {4'd12, 16'd2048}
  };

  always #4 clk = ~clk;

  rtc_irq_gen u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
    @(negedge clk);
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_evt = 1'b1;
    @(negedge clk); update_evt = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: all requirements, actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    do_rd(A_RATE, rv); chk("R1 rate reset", rv, 8'h26);
    do_rd(A_CTRL, rv); chk("R1 ctrl reset", rv, 8'h00);
    do_rd(A_STAT, rv); chk("R1 status reset", rv, 8'h00);

    // R3 vector table: period per code
    for (int v = 0; v < NV; v++) begin
      do_wr(A_RATE, {4'h2, VEC[v][19:16]});
      do_rd(A_STAT, rv);
      ticks(int'(VEC[v][15:0]) - 1);
      do_rd(A_STAT, rv); chk("R3 no flag before period end", rv & 8'h40, 8'h00);
      ticks(1);
      do_rd(A_STAT, rv); chk("R3 periodic flag at period end", rv & 8'h40, 8'h40);
    end

    // R3 slowest code 15: 16384 ticks
    do_wr(A_RATE, 8'h2F);
    ticks(16383);
    do_rd(A_STAT, rv); chk("R3 code15 not early", rv & 8'h40, 8'h00);
    ticks(1);
    do_rd(A_STAT, rv); chk("R3 code15 at 16384 ticks", rv & 8'h40, 8'h40);

    // R2 code 0 disables periodic
    do_wr(A_RATE, 8'h20);
    ticks(100);
    do_rd(A_STAT, rv); chk("R2 code0 quiet", rv, 8'h00);

    // R9 rewrite restarts divider
    do_wr(A_RATE, 8'h26);
    ticks(20);
    do_wr(A_RATE, 8'h26);
    ticks(31);
    do_rd(A_STAT, rv); chk("R9 no early flag after restart", rv & 8'h40, 8'h00);
    ticks(1);
    do_rd(A_STAT, rv); chk("R9 flag one full period after restart", rv & 8'h40, 8'h40);

    // R4 / R5 latch while disabled, layout
    do_wr(A_CTRL, 8'h00);
    pulse_alarm();
    chk("R4 irq low with alarm disabled", {7'd0, irq}, 8'h00);
    do_rd(A_STAT, rv); chk("R4 R5 alarm flag bit5", rv, 8'h20);
    pulse_update();
    do_rd(A_STAT, rv); chk("R5 update flag bit4", rv, 8'h10);

    // R6 late enable raises request
    pulse_update();
    chk("R6 irq low before enable", {7'd0, irq}, 8'h00);
    do_wr(A_SET, 8'h10);
    chk("R6 irq after late enable", {7'd0, irq}, 8'h01);
    do_rd(A_STAT, rv); chk("R6 summary with update", rv, 8'h90);
    chk("R8 irq cleared by read", {7'd0, irq}, 8'h00);

    // R6 periodic enabled, code 1
    do_wr(A_RATE, 8'h21);
    do_wr(A_CTRL, 8'h40);
    ticks(1);
    chk("R6 irq from periodic", {7'd0, irq}, 8'h01);
    do_rd(A_STAT, rv); chk("R5 R6 periodic status", rv, 8'hC0);
    do_wr(A_RATE, 8'h20);

    // R7 set/clear masks
    do_wr(A_CTRL, 8'h8F);
    do_wr(A_SET, 8'hFF);
    do_rd(A_CTRL, rv); chk("R7 set only enables", rv, 8'hFF);
    do_wr(A_CLR, 8'h20);
    do_rd(A_CTRL, rv); chk("R7 clear single enable", rv, 8'hDF);
    do_wr(A_CLR, 8'hFF);
    do_rd(A_CTRL, rv); chk("R7 clear keeps others", rv, 8'h8F);

    // R8 event coinciding with clearing read
    do_wr(A_CTRL, 8'h00);
    do_rd(A_STAT, rv);
    @(negedge clk); reg_rd = 1'b1; reg_addr = A_STAT; alarm_evt = 1'b1;
    @(negedge clk); reg_rd = 1'b0; alarm_evt = 1'b0;
    chk("R8 read shows prior state", reg_rdata, 8'h00);
    do_rd(A_STAT, rv); chk("R8 coinciding alarm kept", rv, 8'h20);
    do_rd(A_STAT, rv); chk("R8 flags cleared", rv, 8'h00);

    // R10 status writes ignored
    do_wr(A_STAT, 8'hFF);
    chk("R10 irq after status write", {7'd0, irq}, 8'h00);
    do_rd(A_STAT, rv); chk("R10 status unchanged", rv, 8'h00);
    do_rd(A_CTRL, rv); chk("R10 ctrl unchanged", rv, 8'h00);

    // R1 mid-run reset
    do_wr(A_CTRL, 8'h20);
    do_wr(A_RATE, 8'h23);
    pulse_alarm();
    chk("R6 alarm irq before reset", {7'd0, irq}, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R1 irq low after reset", {7'd0, irq}, 8'h00);
    do_rd(A_RATE, rv); chk("R1 rate restored", rv, 8'h26);
    do_rd(A_STAT, rv); chk("R1 flags cleared by reset", rv, 8'h00);

    summary();
    $finish;
  end
endmodule